// File: doc/BRIEF.md
# Scratchpad Memory Command Controller

This block is the function layer of a single-wire temperature sensor slave. It starts working once the device has been selected on the bus. It takes command bytes from a byte receiver and answers read time slots with one bit per slot. It keeps a nine-byte scratchpad image, a pair of modelled nonvolatile trigger registers, and the busy state of conversions and copies.

The master first sends a command byte. It then either sends data bytes or issues read slots, depending on the command. A line reset from the bit layer always returns the block to waiting for a command.

- The readout streams the scratchpad least significant bit first. It ends with a CRC byte that is computed bit by bit while the earlier bytes go out.
- Status commands answer each slot with a single flag bit.
- A temperature conversion is requested from an external sensing front end through a start pulse. The front end returns its result together with a completion pulse.

Top module: `scratchpad_cmd_ctrl`

## Requirements
- R1: After rstN is released, txBitValid and convStart are 0 and txBit is 1. Scratchpad bytes 2 and 3 hold the parameters NV_HI_INIT and NV_LO_INIT, which is the automatic power-up recall. Bytes 0, 1, 6 and 7 hold 00h.
- R2: Command BEh streams the scratchpad from byte 0 upward, one bit per txReq, least significant bit first. Each bit appears on txBit with txBitValid high in the cycle after txReq. The byte layout is: 0 = temperature low byte, 1 = temperature high byte, 2 = high trigger, 3 = low trigger, 4 and 5 = FFh, 6 = count remaining, 7 = counts per degree.
- R3: The ninth byte of the readout is the CRC-8 of bytes 0 to 7, fed least significant bit first. The polynomial is x^8+x^5+x^4+1, the register starts at zero, and the shift is right with XOR constant 8Ch. Every slot after the ninth byte returns 1.
- R4: Command 4Eh stores the next received byte in scratchpad byte 2 and the byte after that in byte 3. Later bytes have no effect. A bus reset between the two bytes ends the write and keeps byte 2.
- R5: Command 44h raises convStart for exactly one cycle, in the cycle after the command byte. Until convDone arrives, status slots return 0; afterwards they return 1. On convDone, tempIn, remainIn and perDegIn are loaded into bytes 0/1, 6 and 7.
- R6: Command 48h copies scratchpad bytes 2 and 3 into the nonvolatile pair. Status slots return 0 for NV_WRITE_CYCLES cycles and 1 after that.
- R7: Command B8h reloads scratchpad bytes 2 and 3 from the nonvolatile pair. Its status slots return 0 while a conversion is pending and 1 otherwise.
- R8: After command B4h, each slot returns extPower (0 = parasite supply, 1 = external supply).
- R9: busReset returns the block to waiting for a command. An unknown command code, or a byte received after a command has taken its data, has no effect. Slots outside a read or status command return 1.
- R10: If convDone and a conversion status slot fall in the same cycle, that slot reports 0, which is the state before completion. The next slot reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| busReset | input | 1 | Strobe: line reset detected by the bit layer |
| rxValid | input | 1 | Strobe: rxByte holds a received byte |
| rxByte | input | 8 | Received byte |
| txReq | input | 1 | Strobe: master opened a read slot |
| txBit | output | 1 | Bit to place in the read slot |
| txBitValid | output | 1 | txBit is valid this cycle |
| convStart | output | 1 | One-cycle request to start a conversion |
| convDone | input | 1 | Strobe: conversion result is present on the data inputs |
| tempIn | input | 16 | Signed temperature, half-degree LSB |
| remainIn | input | 8 | Count remaining at end of gate period |
| perDegIn | input | 8 | Counts per degree |
| extPower | input | 1 | 1 when the device has its own supply |

## Verification
Conversion completion and a conversion status slot can land in the same clock edge. When they do, the slot must report the busy state from before completion. The bench provokes this by raising txReq and convDone in the same cycle after a 44h command. It expects 0 from that slot and 1 from the next one. It also checks that the latched result reads back correctly in a following scratchpad readout.

// File: rtl/spad_pkg.sv
package spad_pkg;

  localparam int BYTE_W = 8;
  localparam int SPAD_BYTES = 9;
  localparam int ADDR_W = $clog2(SPAD_BYTES + 1);

  localparam logic [BYTE_W-1:0] CMD_WRITE   = 8'h4E;
  localparam logic [BYTE_W-1:0] CMD_READ    = 8'hBE;
  localparam logic [BYTE_W-1:0] CMD_COPY    = 8'h48;
  localparam logic [BYTE_W-1:0] CMD_CONVERT = 8'h44;
  localparam logic [BYTE_W-1:0] CMD_RECALL  = 8'hB8;
  localparam logic [BYTE_W-1:0] CMD_POWER   = 8'hB4;

  localparam logic [BYTE_W-1:0] CRC_XOR = 8'h8C;

  typedef enum logic [2:0] {
    SRC_ONE,
    SRC_SCRATCH,
    SRC_CONV,
    SRC_COPY,
    SRC_POWER
  } txSrc_e;

  typedef struct packed {
    logic   startRead;
    logic   readSlot;
    logic   wrHi;
    logic   wrLo;
    logic   startCopy;
    logic   doRecall;
    logic   startConv;
    txSrc_e txSrc;
  } dpCtrl_t;

  function automatic logic [BYTE_W-1:0] crcStep(input logic [BYTE_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crcStep = (c >> 1) ^ (fb ? CRC_XOR : '0);
  endfunction

endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txReq,
  output dpCtrl_t           ctl
);

  typedef enum logic [3:0] {
    ST_CMD,
    ST_WR_HI,
    ST_WR_LO,
    ST_READ,
    ST_CONV,
    ST_COPY,
    ST_RECALL,
    ST_POWER,
    ST_IGNORE
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctl = '0;
    case (state)
      ST_READ:   ctl.txSrc = SRC_SCRATCH;
      ST_CONV:   ctl.txSrc = SRC_CONV;
      ST_RECALL: ctl.txSrc = SRC_CONV;
      ST_COPY:   ctl.txSrc = SRC_COPY;
      ST_POWER:  ctl.txSrc = SRC_POWER;
      default:   ctl.txSrc = SRC_ONE;
    endcase
    ctl.readSlot = (state == ST_READ) && txReq;
    if (busReset) begin
      stateNext = ST_CMD;
    end else if (rxValid) begin
      case (state)
        ST_CMD: begin
          case (rxByte)
            CMD_WRITE: stateNext = ST_WR_HI;
            CMD_READ: begin
              stateNext = ST_READ;
              ctl.startRead = 1'b1;
            end
            CMD_COPY: begin
              stateNext = ST_COPY;
              ctl.startCopy = 1'b1;
            end
            CMD_CONVERT: begin
              stateNext = ST_CONV;
              ctl.startConv = 1'b1;
            end
            CMD_RECALL: begin
              stateNext = ST_RECALL;
              ctl.doRecall = 1'b1;
            end
            CMD_POWER: stateNext = ST_POWER;
            default:   stateNext = ST_IGNORE;
          endcase
        end
        ST_WR_HI: begin
          ctl.wrHi = 1'b1;
          stateNext = ST_WR_LO;
        end
        ST_WR_LO: begin
          ctl.wrLo = 1'b1;
          stateNext = ST_IGNORE;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CMD;
    else       state <= stateNext;
  end

  // R9: a line reset always lands in command wait
  p_reset_to_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == ST_CMD));

  // R4: at most one datapath action per cycle
  p_one_action_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.startRead, ctl.wrHi, ctl.wrLo, ctl.startCopy, ctl.doRecall, ctl.startConv}));

  // R4: a trigger write is followed by either the second write or ignore/command wait
  p_write_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrHi && !busReset) |=> (state == ST_WR_LO));

endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter int               NV_WRITE_CYCLES = 20,
  parameter logic [7:0]       NV_HI_INIT      = 8'h4B,
  parameter logic [7:0]       NV_LO_INIT      = 8'h46,
  parameter int               TEMP_W          = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txReq,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic [BYTE_W-1:0] remainIn,
  input  logic [BYTE_W-1:0] perDegIn,
  input  logic              convDone,
  input  logic              extPower,
  output logic              convStart,
  output logic              txBit,
  output logic              txBitValid
);

  localparam int CNT_W = $clog2(NV_WRITE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] CRC_ADDR = ADDR_W'(SPAD_BYTES - 1);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(SPAD_BYTES);

  logic [TEMP_W-1:0] tempQ;
  logic [BYTE_W-1:0] remainQ, perDegQ;
  logic [BYTE_W-1:0] spHi, spLo, nvHi, nvLo;
  logic              convBusy;
  logic [CNT_W-1:0]  copyCnt;
  logic              copyBusy;
  logic [ADDR_W-1:0] rdAddr;
  logic [2:0]        bitIdx;
  logic [BYTE_W-1:0] crcQ;
  logic [BYTE_W-1:0] curByte;
  logic              readBit;
  logic              txBitNext;

  assign copyBusy = (copyCnt != '0);

  always_comb begin
    case (rdAddr)
      4'd0:    curByte = tempQ[7:0];
      4'd1:    curByte = tempQ[TEMP_W-1:8];
      4'd2:    curByte = spHi;
      4'd3:    curByte = spLo;
      4'd6:    curByte = remainQ;
      4'd7:    curByte = perDegQ;
      4'd8:    curByte = crcQ;
      default: curByte = '1;
    endcase
    readBit = (rdAddr < END_ADDR) ? curByte[bitIdx] : 1'b1;
    case (ctl.txSrc)
      SRC_SCRATCH: txBitNext = readBit;
      SRC_CONV:    txBitNext = !convBusy;
      SRC_COPY:    txBitNext = !copyBusy;
      SRC_POWER:   txBitNext = extPower;
      default:     txBitNext = 1'b1;
    endcase
  end

  // measurement latch and conversion handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempQ     <= '0;
      remainQ   <= '0;
      perDegQ   <= '0;
      convBusy  <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= ctl.startConv;
      if (ctl.startConv) convBusy <= 1'b1;
      else if (convDone) convBusy <= 1'b0;
      if (convDone) begin
        tempQ   <= tempIn;
        remainQ <= remainIn;
        perDegQ <= perDegIn;
      end
    end
  end

  // trigger bytes, nonvolatile pair and write-delay timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spHi    <= NV_HI_INIT;
      spLo    <= NV_LO_INIT;
      nvHi    <= NV_HI_INIT;
      nvLo    <= NV_LO_INIT;
      copyCnt <= '0;
    end else begin
      if (ctl.wrHi) spHi <= rxByte;
      if (ctl.wrLo) spLo <= rxByte;
      if (ctl.doRecall) begin
        spHi <= nvHi;
        spLo <= nvLo;
      end
      if (ctl.startCopy) begin
        nvHi    <= spHi;
        nvLo    <= spLo;
        copyCnt <= CNT_W'(NV_WRITE_CYCLES);
      end else if (copyBusy) begin
        copyCnt <= copyCnt - 1'b1;
      end
    end
  end

  // readout pointer and serial CRC
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      bitIdx <= '0;
      crcQ   <= '0;
    end else if (ctl.startRead) begin
      rdAddr <= '0;
      bitIdx <= '0;
      crcQ   <= '0;
    end else if (ctl.readSlot && rdAddr < END_ADDR) begin
      if (rdAddr < CRC_ADDR) crcQ <= crcStep(crcQ, readBit);
      bitIdx <= bitIdx + 1'b1;
      if (bitIdx == 3'd7) rdAddr <= rdAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit      <= 1'b1;
      txBitValid <= 1'b0;
    end else begin
      txBitValid <= txReq;
      if (txReq) txBit <= txBitNext;
    end
  end

  p_rd_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr <= END_ADDR);

  p_tail_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && ctl.txSrc == SRC_SCRATCH && rdAddr == END_ADDR) |=> txBit);

  p_crc_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readSlot && rdAddr == CRC_ADDR && !ctl.startRead) |=> $stable(crcQ));

  p_conv_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !ctl.startConv) |=> !convBusy);

  p_conv_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> convBusy);

  p_copy_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && ctl.txSrc == SRC_COPY && copyBusy) |=> !txBit);

  p_power_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && ctl.txSrc == SRC_POWER) |=> (txBit == $past(extPower)));

endmodule

// File: rtl/scratchpad_cmd_ctrl.sv
module scratchpad_cmd_ctrl
  import spad_pkg::*;
#(
  parameter int         NV_WRITE_CYCLES = 20,
  parameter logic [7:0] NV_HI_INIT      = 8'h4B,
  parameter logic [7:0] NV_LO_INIT      = 8'h46
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReset,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        txReq,
  output logic        txBit,
  output logic        txBitValid,
  output logic        convStart,
  input  logic        convDone,
  input  logic [15:0] tempIn,
  input  logic [7:0]  remainIn,
  input  logic [7:0]  perDegIn,
  input  logic        extPower
);

  dpCtrl_t ctl;

  spad_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .txReq    (txReq),
    .ctl      (ctl)
  );

  spad_datapath #(
    .NV_WRITE_CYCLES (NV_WRITE_CYCLES),
    .NV_HI_INIT      (NV_HI_INIT),
    .NV_LO_INIT      (NV_LO_INIT),
    .TEMP_W          (16)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .rxByte     (rxByte),
    .txReq      (txReq),
    .tempIn     (tempIn),
    .remainIn   (remainIn),
    .perDegIn   (perDegIn),
    .convDone   (convDone),
    .extPower   (extPower),
    .convStart  (convStart),
    .txBit      (txBit),
    .txBitValid (txBitValid)
  );

endmodule

// File: tb/scratchpad_cmd_ctrl_tb_top.sv
module scratchpad_cmd_ctrl_tb_top;

  localparam int NVW = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txReq = 1'b0;
  logic        txBit, txBitValid, convStart;
  logic        convDone = 1'b0;
  logic [15:0] tempIn = '0;
  logic [7:0]  remainIn = '0;
  logic [7:0]  perDegIn = '0;
  logic        extPower = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // bench model of scratchpad contents
  logic [15:0] mTemp = '0;
  logic [7:0]  mRem = '0, mPer = '0, mHi = 8'h4B, mLo = 8'h46;

  always #2 clk = ~clk;

  scratchpad_cmd_ctrl #(.NV_WRITE_CYCLES(NVW)) dut_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid), .rxByte(rxByte),
    .txReq(txReq), .txBit(txBit), .txBitValid(txBitValid), .convStart(convStart),
    .convDone(convDone), .tempIn(tempIn), .remainIn(remainIn), .perDegIn(perDegIn),
    .extPower(extPower)
  );

  // vectors: {temperature, count remain, counts per degree, high trigger, low trigger}
  localparam logic [47:0] VEC [4] = '{
    48'h0032_0C_10_50_0A,
    48'hFFCE_03_10_1E_EC,
    48'h00FA_00_10_7D_00,
    48'hFF92_0F_10_19_C9
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crcModel(input logic [7:0] data [8]);
    logic [7:0] c = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[0] ^ data[i][j];
        c = {1'b0, c[7:1]};
        if (fb) c = c ^ 8'h8C;
      end
    return c;
  endfunction

  task automatic sendByte(input logic [7:0] b, output logic sawStart);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0; sawStart = convStart;
  endtask

  task automatic lineReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic readBit(output logic b, output logic v);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0; b = txBit; v = txBitValid;
  endtask

  task automatic readByte(output logic [7:0] val);
    logic b, v;
    for (int i = 0; i < 8; i++) begin
      readBit(b, v);
      val[i] = b;
    end
  endtask

  task automatic pulseDone(input logic [15:0] t, input logic [7:0] r, input logic [7:0] p);
    @(negedge clk); convDone = 1'b1; tempIn = t; remainIn = r; perDegIn = p;
    @(negedge clk); convDone = 1'b0;
    mTemp = t; mRem = r; mPer = p;
  endtask

  task automatic readCheck(input string tag);
    logic [7:0] exp [8];
    logic [7:0] got;
    logic s, b, v;
    exp[0] = mTemp[7:0]; exp[1] = mTemp[15:8]; exp[2] = mHi; exp[3] = mLo;
    exp[4] = 8'hFF; exp[5] = 8'hFF; exp[6] = mRem; exp[7] = mPer;
    lineReset();
    sendByte(8'hBE, s);
    for (int i = 0; i < 8; i++) begin
      readByte(got);
      check($sformatf("R2 %s byte%0d", tag, i), {8'h00, got}, {8'h00, exp[i]});
    end
    readByte(got);
    check($sformatf("R3 %s crc", tag), {8'h00, got}, {8'h00, crcModel(exp)});
    readBit(b, v);
    check($sformatf("R3 %s trailing slot", tag), {15'd0, b}, 16'd1);
  endtask

  initial begin
    logic s, b, v;
    logic [7:0] nvHiM, nvLoM;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 txBitValid at reset", {15'd0, txBitValid}, 16'd0);
    check("R1 convStart at reset", {15'd0, convStart}, 16'd0);
    check("R1 txBit at reset", {15'd0, txBit}, 16'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txBitValid after release", {15'd0, txBitValid}, 16'd0);
    readCheck("R1 power-up image");
    nvHiM = 8'h4B; nvLoM = 8'h46;

    // R2 bit timing: valid the cycle after txReq only
    lineReset(); sendByte(8'hBE, s);
    check("R2 no convStart on read", {15'd0, s}, 16'd0);
    readBit(b, v);
    check("R2 txBitValid after slot", {15'd0, v}, 16'd1);
    @(negedge clk);
    check("R2 txBitValid drops", {15'd0, txBitValid}, 16'd0);

    // vector loop: R4 write, R5 convert, R2/R3 readout
    foreach (VEC[k]) begin
      lineReset();
      sendByte(8'h4E, s);
      sendByte(VEC[k][15:8], s);
      sendByte(VEC[k][7:0], s);
      mHi = VEC[k][15:8]; mLo = VEC[k][7:0];
      lineReset();
      sendByte(8'h44, s);
      check("R5 convStart pulse", {15'd0, s}, 16'd1);
      @(negedge clk);
      check("R5 convStart one cycle", {15'd0, convStart}, 16'd0);
      readBit(b, v);
      check("R5 busy slot", {15'd0, b}, 16'd0);
      pulseDone(VEC[k][47:32], VEC[k][31:24], VEC[k][23:16]);
      readBit(b, v);
      check("R5 done slot", {15'd0, b}, 16'd1);
      readCheck($sformatf("R4 R5 vector %0d", k));
    end

    // R4: third data byte ignored
    lineReset();
    sendByte(8'h4E, s); sendByte(8'h11, s); sendByte(8'h22, s); sendByte(8'h33, s);
    mHi = 8'h11; mLo = 8'h22;
    readCheck("R4 extra byte");

    // R4: reset between data bytes keeps the first
    lineReset();
    sendByte(8'h4E, s); sendByte(8'h55, s);
    mHi = 8'h55;
    readCheck("R4 reset mid write");

    // R6: copy with busy window, R7 recall
    lineReset();
    sendByte(8'h4E, s); sendByte(8'hA1, s); sendByte(8'hB2, s);
    mHi = 8'hA1; mLo = 8'hB2;
    lineReset(); sendByte(8'h48, s);
    nvHiM = mHi; nvLoM = mLo;
    readBit(b, v);
    check("R6 copy busy", {15'd0, b}, 16'd0);
    repeat (NVW + 4) @(negedge clk);
    readBit(b, v);
    check("R6 copy done", {15'd0, b}, 16'd1);
    lineReset();
    sendByte(8'h4E, s); sendByte(8'h0C, s); sendByte(8'h0D, s);
    mHi = 8'h0C; mLo = 8'h0D;
    readCheck("R4 pre-recall");
    lineReset(); sendByte(8'hB8, s);
    mHi = nvHiM; mLo = nvLoM;
    readBit(b, v);
    check("R7 recall idle status", {15'd0, b}, 16'd1);
    readCheck("R7 recalled");

    // R7: recall status while conversion pending; R9 byte after convert ignored
    lineReset(); sendByte(8'h44, s);
    sendByte(8'hBE, s);
    readBit(b, v);
    check("R9 byte after convert ignored", {15'd0, b}, 16'd0);
    lineReset(); sendByte(8'hB8, s);
    readBit(b, v);
    check("R7 recall status busy", {15'd0, b}, 16'd0);
    pulseDone(16'h0019, 8'h05, 8'h10);
    readBit(b, v);
    check("R7 recall status done", {15'd0, b}, 16'd1);

    // R8: supply mode
    extPower = 1'b0;
    lineReset(); sendByte(8'hB4, s);
    readBit(b, v);
    check("R8 parasite", {15'd0, b}, 16'd0);
    extPower = 1'b1;
    readBit(b, v);
    check("R8 external", {15'd0, b}, 16'd1);

    // R9: unknown command and idle slots
    lineReset();
    readBit(b, v);
    check("R9 idle slot", {15'd0, b}, 16'd1);
    sendByte(8'h99, s);
    check("R9 unknown no convStart", {15'd0, s}, 16'd0);
    readBit(b, v);
    check("R9 unknown slot", {15'd0, b}, 16'd1);
    readCheck("R9 unchanged");

    // R10: completion and status slot in the same cycle
    lineReset(); sendByte(8'h44, s);
    readBit(b, v);
    check("R10 busy before", {15'd0, b}, 16'd0);
    @(negedge clk);
    txReq = 1'b1; convDone = 1'b1; tempIn = 16'hFFFF; remainIn = 8'h0A; perDegIn = 8'h10;
    @(negedge clk);
    txReq = 1'b0; convDone = 1'b0;
    mTemp = 16'hFFFF; mRem = 8'h0A; mPer = 8'h10;
    check("R10 coincident slot", {15'd0, txBit}, 16'd0);
    readBit(b, v);
    check("R10 following slot", {15'd0, b}, 16'd1);
    readCheck("R10 latched result");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule